// File: doc/BRIEF.md
# Write-Busy Status Read Logic

This block forms the byte a nonvolatile memory returns on a read while its internal write timer is running, so that a host can poll for the end of the write. It keeps a copy of the most recent data byte accepted for writing. While the write is in progress, a read shows status instead of stored data. The top bit carries the inverse of the top bit of that remembered byte. The bit below it flips on every read access. The remaining low bits still carry the array contents at the read address. When no write is in progress, every read passes the array byte through unchanged.

The block is a two-state machine clocked by the memory's core clock. In state `MODE_PASS`, reads return plain array data. In state `MODE_POLL`, reads return the status byte. The transition `START` (`MODE_PASS` to `MODE_POLL`) is taken on any clock where `busy` is high. The transition `DONE` (`MODE_POLL` to `MODE_PASS`) is taken on any clock where `busy` is low. The busy signal comes from the write timer. It stays high for a full timer period even when a protected write attempt stored nothing. Such periods therefore also poll, and they report against the byte remembered from the last load.

Each read is a one-clock strobe. The returned byte is registered on the strobe and holds until the next strobe.

Top module: `busy_poll_read`

## Requirements
- R1: After reset, `rd_data` is all zeros and the machine is in `MODE_PASS`.
- R2: A clock with `wr_load` high stores `wr_data` as the remembered byte. The remembered byte keeps that value across any number of busy periods until the next load. A load during a busy period takes effect for the following polling reads.
- R3: The mode follows `busy` one clock late. A read strobed in the same clock that `busy` first rises still returns plain data. A read strobed in the same clock that `busy` first falls still returns status.
- R4: In `MODE_PASS`, a read strobe makes `rd_data` equal to the `arr_data` present in the strobe clock, on all bits, from the next clock on.
- R5: In `MODE_POLL`, a read makes bit DATA_W-1 (bit 7 by default) of `rd_data` the inverse of bit DATA_W-1 of the remembered byte.
- R6: In `MODE_POLL`, bit DATA_W-2 (bit 6 by default) of `rd_data` takes the opposite value on each read from the value shown by the previous polling read. Clocks without a strobe do not advance it. Its value before the first polling read is not defined.
- R7: In `MODE_POLL`, bits DATA_W-3 down to 0 (5..0 by default) of `rd_data` equal those of `arr_data` in the strobe clock.
- R8: In clocks without a read strobe, `rd_data` holds its value, whatever `arr_data` does.
- R9: The toggle state does not move in `MODE_PASS`. The first polling read of a new busy period therefore shows the inverse of the last polling read of the previous period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| busy | input | 1 | Write timer running |
| rd_stb | input | 1 | One-clock read access strobe |
| wr_load | input | 1 | Accepted data byte load |
| wr_data | input | DATA_W | Byte being loaded |
| arr_data | input | DATA_W | Array data at the read address |
| rd_data | output | DATA_W | Byte returned to the host |

## Verification
The bench builds the block with DATA_W = 8. At that width, every one of the 256 array values can be read in `MODE_PASS`. Every one of the 256 remembered bytes can be loaded and polled, with two polling reads per byte. This covers both values of the polled bit against every pattern of the low bits. The toggle is checked across the boundaries of 256 separate busy periods. Directed cases cover the one-clock lag of `START` and `DONE`, and a load arriving inside a busy period.

// File: rtl/busy_poll_pkg.sv
package busy_poll_pkg;
    typedef enum logic {
        MODE_PASS = 1'b0,
        MODE_POLL = 1'b1
    } mode_e;
endpackage

// File: rtl/bp_last_byte.sv
module bp_last_byte #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] last_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            last_q <= '0;
        end else if (load) begin
            last_q <= din;
        end
    end

    // R2
    last_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> last_q == $past(din));
endmodule

// File: rtl/bp_toggle.sv
module bp_toggle (
    input  logic clk,
    input  logic rst_n,
    input  logic advance,
    output logic tgl_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tgl_q <= 1'b0;
        end else if (advance) begin
            tgl_q <= ~tgl_q;
        end
    end

    // R6
    toggle_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !advance |=> $stable(tgl_q));
endmodule

// File: rtl/bp_mode_fsm.sv
module bp_mode_fsm
    import busy_poll_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  busy,
    output mode_e mode
);
    mode_e mode_q, mode_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= MODE_PASS;
        end else begin
            mode_q <= mode_d;
        end
    end

    always_comb begin
        mode_d = mode_q;
        unique case (mode_q)
            MODE_PASS: if (busy)  mode_d = MODE_POLL;  // START
            MODE_POLL: if (!busy) mode_d = MODE_PASS;  // DONE
        endcase
    end

    assign mode = mode_q;

    // R3
    start_lag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> mode_q == MODE_POLL);
    // R3
    done_lag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |=> mode_q == MODE_PASS);
endmodule

// File: rtl/busy_poll_read.sv
module busy_poll_read
    import busy_poll_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              busy,
    input  logic              rd_stb,
    input  logic              wr_load,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [DATA_W-1:0] arr_data,
    output logic [DATA_W-1:0] rd_data
);
    localparam int POLL_BIT = DATA_W - 1;
    localparam int TGL_BIT  = DATA_W - 2;
    localparam int LOW_W    = DATA_W - 2;

    mode_e             mode;
    logic [DATA_W-1:0] last_q;
    logic              tgl_q;
    logic [DATA_W-1:0] rd_next;
    logic [DATA_W-1:0] rd_q;

    bp_mode_fsm u_fsm (
        .clk   (clk),
        .rst_n (rst_n),
        .busy  (busy),
        .mode  (mode)
    );

    bp_last_byte #(.DATA_W(DATA_W)) u_last (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (wr_load),
        .din    (wr_data),
        .last_q (last_q)
    );

    bp_toggle u_tgl (
        .clk     (clk),
        .rst_n   (rst_n),
        .advance (rd_stb && (mode == MODE_POLL)),
        .tgl_q   (tgl_q)
    );

    always_comb begin
        rd_next = arr_data;
        unique case (mode)
            MODE_PASS: rd_next = arr_data;
            MODE_POLL: begin
                rd_next[POLL_BIT] = ~last_q[POLL_BIT];
                rd_next[TGL_BIT]  = tgl_q;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_q <= '0;
        end else if (rd_stb) begin
            rd_q <= rd_next;
        end
    end

    assign rd_data = rd_q;

    // R4
    pass_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && mode == MODE_PASS) |=> rd_data == $past(arr_data));
    // R5
    poll_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && mode == MODE_POLL) |=> rd_data[POLL_BIT] != $past(last_q[POLL_BIT]));
    // R7
    poll_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && mode == MODE_POLL) |=> rd_data[LOW_W-1:0] == $past(arr_data[LOW_W-1:0]));
    // R8
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_stb |=> $stable(rd_data));
    // R9
    toggle_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_PASS) |=> $stable(tgl_q));
endmodule

// File: tb/busy_poll_read_tb.sv
module busy_poll_read_tb;
    localparam int CLK_P  = 10;
    localparam int DATA_W = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              busy = 1'b0;
    logic              rd_stb = 1'b0;
    logic              wr_load = 1'b0;
    logic [DATA_W-1:0] wr_data = '0;
    logic [DATA_W-1:0] arr_data = '0;
    logic [DATA_W-1:0] rd_data;

    int n_chk = 0;
    int n_bad = 0;
    logic [DATA_W-1:0] last_byte = '0;
    logic have_prev = 1'b0;
    logic prev6 = 1'b0;
    logic finished = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    busy_poll_read #(.DATA_W(DATA_W)) u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .busy     (busy),
        .rd_stb   (rd_stb),
        .wr_load  (wr_load),
        .wr_data  (wr_data),
        .arr_data (arr_data),
        .rd_data  (rd_data)
    );

    task automatic check(input string req, input logic [DATA_W-1:0] got,
                         input logic [DATA_W-1:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %02h expected %02h", req, got, exp);
        end
    endtask

    task automatic load(input logic [DATA_W-1:0] d);
        wr_load = 1'b1; wr_data = d;
        @(negedge clk);
        wr_load = 1'b0;
        last_byte = d;
    endtask

    task automatic set_busy(input logic b);
        busy = b;
        @(negedge clk);
    endtask

    task automatic read_pass(input logic [DATA_W-1:0] a, input string req);
        arr_data = a; rd_stb = 1'b1;
        @(negedge clk);
        rd_stb = 1'b0;
        check(req, rd_data, a);
    endtask

    task automatic read_poll(input logic [DATA_W-1:0] a, input string req_tgl);
        logic [DATA_W-1:0] exp;
        arr_data = a; rd_stb = 1'b1;
        @(negedge clk);
        rd_stb = 1'b0;
        check("R5", {rd_data[7], 7'b0}, {~last_byte[7], 7'b0});
        check("R7", {2'b0, rd_data[5:0]}, {2'b0, a[5:0]});
        if (have_prev) begin
            exp = {1'b0, ~prev6, 6'b0};
            check(req_tgl, {1'b0, rd_data[6], 6'b0}, exp);
        end
        have_prev = 1'b1;
        prev6 = rd_data[6];
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset value
        check("R1", rd_data, '0);
        // R1: comes out of reset in pass mode
        read_pass(8'hC3, "R1");

        // R4 sweep, R8 hold with moving array data
        for (int a = 0; a < 256; a++) begin
            read_pass(a[7:0], "R4");
            arr_data = ~a[7:0];
            @(negedge clk);
            @(negedge clk);
            check("R8", rd_data, a[7:0]);
        end

        // R5/R6/R7/R9 sweep over remembered bytes
        for (int d = 0; d < 256; d++) begin
            load(d[7:0]);
            set_busy(1'b1);
            read_poll(d[7:0] ^ 8'h5A, "R9");
            repeat (2) @(negedge clk);  // idle clocks must not advance the toggle
            read_poll(~d[7:0], "R6");
            set_busy(1'b0);
            read_pass(d[7:0], "R4");
        end

        // R3: strobe in the clock busy rises still passes data
        busy = 1'b1; arr_data = 8'hE7; rd_stb = 1'b1;
        @(negedge clk);
        rd_stb = 1'b0;
        check("R3", rd_data, 8'hE7);
        read_poll(8'h11, "R6");
        // R3: strobe in the clock busy falls still polls
        busy = 1'b0;
        read_poll(8'h2C, "R6");
        @(negedge clk);
        read_pass(8'h4B, "R3");

        // R2: remembered byte survives a busy period without a load
        load(8'h00);
        set_busy(1'b1);
        read_poll(8'h3F, "R6");
        set_busy(1'b0);
        set_busy(1'b1);
        read_poll(8'h00, "R9");
        check("R2", {rd_data[7], 7'b0}, 8'h80);
        // R2: a load inside the busy period takes effect
        load(8'h80);
        read_poll(8'h15, "R6");
        check("R2", {rd_data[7], 7'b0}, 8'h00);
        set_busy(1'b0);
        read_pass(8'h9D, "R4");

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule